// File: doc/BRIEF.md
# Heat/Cool Direction PWM Modulator

This block turns a signed drive command into the two logic-level controls of a thermoelectric load driver. One output is a direction line that stays at a fixed level for the whole time a mode is held: low selects cooling, high selects heating. The other output is a pulse-width-modulated line. Only that line switches, and its duty cycle sets the magnitude of the voltage across the load. In cooling the duty grows with the command. In heating the duty is the complement, so a stronger heating command gives a shorter high time.

The mode decision has a hysteresis band around zero, so a command that hovers near zero cannot make the direction line chatter. As the command moves from the cooling side toward heating, the duty first falls toward zero while the direction line stays low. Once the command leaves the band, the direction goes high and the duty starts near full scale. The load voltage therefore stays small across the change of mode.

The carrier comes from one of two sources. The first is an internal prescaler with a fast rate and a slow rate, chosen by a select input. The second is an external clock at half the wanted tick rate: it is synchronized and doubled by taking a tick on each of its edges. A free-running counter compares against a duty register. The mode and the duty are taken only when the counter wraps, so no pulse is ever cut short. An active-low shutdown input and an active-high fault-disable input both force the two outputs low.

Top module: `tec_pwm_mod`

## Requirements
- R1: While reset is held, and after its release until the first carrier period boundary, both pwmOut and dirOut are low. The block leaves reset in cooling mode with duty 0.
- R2: In cooling mode (dirOut low), for a command c > 0, pwmOut is high for min(2·c, 1023) of the 1024 ticks in each carrier period. For a command c ≤ 0 it is high for 0 ticks.
- R3: In heating mode (dirOut high, held for the whole period), for a command c < 0, pwmOut is high for min(1024 + 2·c, 1023) ticks per period. For a command c ≥ 0 it is high for 1023 ticks.
- R4: With the hysteresis band HYST = 8, a command in −8..−1 entered from cooling keeps the block in cooling with duty 0. A command in 0..8 entered from heating keeps it in heating with duty 1023.
- R5: The block enters heating only when the command is below −HYST (for example −9). It returns to cooling only when the command is above +HYST (for example +9).
- R6: The duty and the mode change only at a carrier period boundary. A command change in mid-period leaves the current pulse at its old width, and the following pulse takes the new width. dirOut never changes inside a period while the enables are steady.
- R7: In internal mode (intSel high) there is one tick every FAST_DIV = 1 clock when freqSel is low, giving a 1024-clock period. There is one tick every SLOW_DIV = 5 clocks when freqSel is high, giving a 5120-clock period.
- R8: In external mode (intSel low), extClk passes through a two-stage synchronizer, and each rising or falling edge gives one tick. An extClk that toggles every 3 clocks gives a 3072-clock period with unchanged duty.
- R9: When shdnN is low or faultOff is high, pwmOut and dirOut are both low from the next clock on. When the disable is released, the previous mode and duty return.
- R10: The largest commands saturate cleanly: +511 gives a duty of 1022 in cooling, and −512 gives a duty of 0 in heating with dirOut still high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdIn | input | 10 | Signed two's-complement drive command; positive cools, negative heats |
| freqSel | input | 1 | Internal carrier rate: 0 fast, 1 slow |
| intSel | input | 1 | Carrier source: 1 internal prescaler, 0 doubled external clock |
| extClk | input | 1 | External carrier clock (asynchronous, half the tick rate) |
| shdnN | input | 1 | Active-low shutdown; low forces both outputs low |
| faultOff | input | 1 | Fault disable; high forces both outputs low |
| pwmOut | output | 1 | Pulse-width-modulated magnitude line |
| dirOut | output | 1 | Direction line: 0 cooling, 1 heating |

## Verification
A command change reaches the hysteresis state after one clock. It then waits up to one full period for the counter to wrap, and after that the outputs take two more clocks. Every duty check therefore lets a settle time of 1.125 periods plus a few clocks pass. It then counts the high clocks of pwmOut and dirOut over a window of exactly one period, and that count does not depend on the phase of the window. The mid-period update check finds a rising edge of pwmOut, changes the command 50 clocks later, and measures the width of that pulse and of the next one. The disable checks sample on the first falling clock edge after the input changes, because the outputs are registered one clock behind it.

// File: rtl/tec_pwm_pkg.sv
package tec_pwm_pkg;
  // Strobes handed from the control half to the datapath half.
  typedef struct packed {
    logic tick;      // one carrier tick
    logic heatNext;  // mode chosen by the hysteresis decision
  } pwm_strobe_t;
endpackage

// File: rtl/tec_pwm_ctrl.sv
module tec_pwm_ctrl
  import tec_pwm_pkg::*;
#(
  parameter int CMD_W    = 10,
  parameter int HYST     = 8,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [CMD_W-1:0] cmdIn,
  input  logic                    freqSel,
  input  logic                    intSel,
  input  logic                    extClk,
  output pwm_strobe_t             strobes
);
  localparam int DIV_W = (SLOW_DIV > FAST_DIV) ? $clog2(SLOW_DIV + 1) : $clog2(FAST_DIV + 1);
  localparam logic [DIV_W-1:0] FAST_LIM = DIV_W'(FAST_DIV - 1);
  localparam logic [DIV_W-1:0] SLOW_LIM = DIV_W'(SLOW_DIV - 1);
  localparam logic signed [CMD_W-1:0] HYST_POS = CMD_W'(HYST);
  localparam logic signed [CMD_W-1:0] HYST_NEG = -HYST_POS;

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLim;
  logic             intTick;
  logic             extMeta, extSync, extPrev;
  logic             extTick;
  logic             heatState;

  // Internal carrier prescaler
  assign divLim  = freqSel ? SLOW_LIM : FAST_LIM;
  assign intTick = (divCnt >= divLim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divCnt <= '0;
    else if (intTick) divCnt <= '0;
    else divCnt <= divCnt + DIV_W'(1);
  end

  // External clock: synchronize, then tick on both edges (doubling)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMeta <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extMeta <= extClk;
      extSync <= extMeta;
      extPrev <= extSync;
    end
  end
  assign extTick = extSync ^ extPrev;

  // Mode decision with a dead band around zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) heatState <= 1'b0;
    else if (cmdIn < HYST_NEG) heatState <= 1'b1;
    else if (cmdIn > HYST_POS) heatState <= 1'b0;
  end

  always_comb begin
    strobes.tick     = intSel ? intTick : extTick;
    strobes.heatNext = heatState;
  end
endmodule

// File: rtl/tec_pwm_dp.sv
module tec_pwm_dp
  import tec_pwm_pkg::*;
#(
  parameter int CMD_W = 10,
  parameter int CNT_W = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [CMD_W-1:0] cmdIn,
  input  pwm_strobe_t             strobes,
  input  logic                    shdnN,
  input  logic                    faultOff,
  output logic                    pwmOut,
  output logic                    dirOut
);
  localparam int SHIFT = CNT_W - CMD_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W:0]   FULL    = (CNT_W+1)'(1) << CNT_W;
  localparam logic [CNT_W:0]   MAX_EXT = {1'b0, CNT_MAX};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] dutyReg;
  logic             heatReg;
  logic [CMD_W:0]   cmdExt;
  logic [CMD_W:0]   absVal;
  logic [CNT_W:0]   scaled;
  logic [CNT_W:0]   heatDiff;
  logic [CNT_W-1:0] coolDuty, heatDuty, dutyNext;
  logic             isNeg, wrap, enable;

  // Magnitude scaling and per-mode duty
  always_comb begin
    isNeg    = cmdIn[CMD_W-1];
    cmdExt   = {cmdIn[CMD_W-1], cmdIn};
    absVal   = isNeg ? (~cmdExt + (CMD_W+1)'(1)) : cmdExt;
    scaled   = (CNT_W+1)'(absVal) << SHIFT;
    heatDiff = FULL - scaled;

    if (isNeg) coolDuty = '0;
    else if (scaled > MAX_EXT) coolDuty = CNT_MAX;
    else coolDuty = scaled[CNT_W-1:0];

    if (!isNeg) heatDuty = CNT_MAX;
    else if (heatDiff > MAX_EXT) heatDuty = CNT_MAX;
    else heatDuty = heatDiff[CNT_W-1:0];

    dutyNext = strobes.heatNext ? heatDuty : coolDuty;
  end

  assign wrap   = strobes.tick && (cnt == CNT_MAX);
  assign enable = shdnN && !faultOff;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      dutyReg <= '0;
      heatReg <= 1'b0;
    end else begin
      if (strobes.tick) cnt <= cnt + CNT_W'(1);
      if (wrap) begin
        dutyReg <= dutyNext;
        heatReg <= strobes.heatNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwmOut <= 1'b0;
      dirOut <= 1'b0;
    end else begin
      pwmOut <= enable && (cnt < dutyReg);
      dirOut <= enable && heatReg;
    end
  end
endmodule

// File: rtl/tec_pwm_mod.sv
module tec_pwm_mod
  import tec_pwm_pkg::*;
#(
  parameter int CMD_W    = 10,
  parameter int CNT_W    = 10,
  parameter int HYST     = 8,
  parameter int FAST_DIV = 1,
  parameter int SLOW_DIV = 5
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic signed [CMD_W-1:0] cmdIn,
  input  logic                    freqSel,
  input  logic                    intSel,
  input  logic                    extClk,
  input  logic                    shdnN,
  input  logic                    faultOff,
  output logic                    pwmOut,
  output logic                    dirOut
);
  pwm_strobe_t strobes;

  tec_pwm_ctrl #(
    .CMD_W(CMD_W), .HYST(HYST), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .freqSel(freqSel),
    .intSel(intSel), .extClk(extClk), .strobes(strobes)
  );

  tec_pwm_dp #(
    .CMD_W(CMD_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .strobes(strobes),
    .shdnN(shdnN), .faultOff(faultOff), .pwmOut(pwmOut), .dirOut(dirOut)
  );
endmodule

// File: rtl/tec_pwm_mod_chk.sv
module tec_pwm_mod_chk (
  input logic clk,
  input logic rstN,
  input logic freqSel,
  input logic intSel,
  input logic extClk,
  input logic shdnN,
  input logic faultOff,
  input logic tick,
  input logic pwmOut,
  input logic dirOut
);
  // R9
  disable_forces_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!shdnN || faultOff) |=> (!pwmOut && !dirOut));

  // R8
  ext_edge_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !intSel |-> (tick == ($past(extClk, 2) != $past(extClk, 3))));

  // R6
  dir_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((dirOut != $past(dirOut)) && ($past(shdnN, 1) == $past(shdnN, 2)) &&
     ($past(faultOff, 1) == $past(faultOff, 2))) |-> $past(tick, 2));

  // R7
  slow_tick_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intSel && freqSel && $past(intSel) && $past(freqSel) && tick) |=> !tick);
endmodule

bind tec_pwm_mod tec_pwm_mod_chk u_chk (
  .clk(clk), .rstN(rstN), .freqSel(freqSel), .intSel(intSel), .extClk(extClk),
  .shdnN(shdnN), .faultOff(faultOff), .tick(strobes.tick),
  .pwmOut(pwmOut), .dirOut(dirOut)
);

// File: tb/tec_pwm_mod_tb.sv
module tec_pwm_mod_tb;
  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic signed [9:0] cmdIn = '0;
  logic              freqSel = 1'b0;
  logic              intSel = 1'b1;
  logic              extClk = 1'b0;
  logic              extRun = 1'b0;
  logic              shdnN = 1'b1;
  logic              faultOff = 1'b0;
  logic              pwmOut, dirOut;
  int                extDiv = 0;
  int                checks = 0;
  int                failures = 0;
  bit                done = 1'b0;

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (extRun) begin
      if (extDiv == 2) begin
        extClk <= ~extClk;
        extDiv <= 0;
      end else begin
        extDiv <= extDiv + 1;
      end
    end
  end

  tec_pwm_mod u_dut (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .freqSel(freqSel), .intSel(intSel),
    .extClk(extClk), .shdnN(shdnN), .faultOff(faultOff),
    .pwmOut(pwmOut), .dirOut(dirOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic measure(input int win, output int hi, output int dh);
    hi = 0;
    dh = 0;
    for (int i = 0; i < win; i++) begin
      @(negedge clk);
      hi += int'(pwmOut);
      dh += int'(dirOut);
    end
  endtask

  task automatic runDuty(input string req, input int c, input int expDuty,
                         input int expDir, input int period);
    int hi, dh;
    @(negedge clk);
    cmdIn = 10'(c);
    repeat (period + period / 8 + 8) @(negedge clk);
    measure(period, hi, dh);
    chk({req, " duty"}, hi, expDuty * period / 1024);
    chk({req, " dir"}, dh, expDir ? period : 0);
  endtask

  task automatic waitRise();
    logic prev;
    prev = pwmOut;
    forever begin
      @(negedge clk);
      if (pwmOut && !prev) break;
      prev = pwmOut;
    end
  endtask

  task automatic measPeriod(output int p);
    logic prev;
    waitRise();
    p = 0;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      p++;
      if (pwmOut && !prev) break;
      prev = pwmOut;
    end
  endtask

  task automatic tReset();
    repeat (5) @(negedge clk);
    chk("R1 pwm in reset", int'(pwmOut), 0);
    chk("R1 dir in reset", int'(dirOut), 0);
    rstN = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 pwm after reset", int'(pwmOut), 0);
    chk("R1 dir after reset", int'(dirOut), 0);
  endtask

  task automatic tCoolHeat();
    runDuty("R2 cool 100", 100, 200, 0, 1024);
    runDuty("R10 cool 511", 511, 1022, 0, 1024);
    runDuty("R2 cool 1", 1, 2, 0, 1024);
    runDuty("R4 cool hold -5", -5, 0, 0, 1024);
    runDuty("R4 r5_ cool hold -8", -8, 0, 0, 1024);
    runDuty("R5 enter heat -9", -9, 1006, 1, 1024);
    runDuty("R3 heat -200", -200, 624, 1, 1024);
    runDuty("R10 heat -512", -512, 0, 1, 1024);
    runDuty("R4 heat hold 5", 5, 1023, 1, 1024);
    runDuty("R4 r5_ heat hold 8", 8, 1023, 1, 1024);
    runDuty("R5 enter cool 9", 9, 18, 0, 1024);
  endtask

  task automatic tUpdate();
    int w;
    runDuty("R6 setup 100", 100, 200, 0, 1024);
    waitRise();
    repeat (50) @(negedge clk);
    cmdIn = 10'sd300;
    w = 51;
    while (pwmOut) begin
      @(negedge clk);
      if (pwmOut) w++;
    end
    chk("R6 current pulse kept", w, 200);
    waitRise();
    w = 1;
    forever begin
      @(negedge clk);
      if (!pwmOut) break;
      w++;
    end
    chk("R6 next pulse new", w, 600);
  endtask

  task automatic tRate();
    int p;
    runDuty("R7 fast 100", 100, 200, 0, 1024);
    measPeriod(p);
    chk("R7 fast period", p, 1024);
    @(negedge clk);
    freqSel = 1'b1;
    runDuty("R7 slow 100", 100, 200, 0, 5120);
    measPeriod(p);
    chk("R7 slow period", p, 5120);
    @(negedge clk);
    freqSel = 1'b0;
  endtask

  task automatic tExt();
    int p;
    @(negedge clk);
    extRun = 1'b1;
    intSel = 1'b0;
    runDuty("R8 ext 100", 100, 200, 0, 3072);
    measPeriod(p);
    chk("R8 ext period", p, 3072);
    @(negedge clk);
    intSel = 1'b1;
    extRun = 1'b0;
  endtask

  task automatic tOff();
    int hi, dh;
    runDuty("R9 setup heat", -200, 624, 1, 1024);
    @(negedge clk);
    shdnN = 1'b0;
    @(negedge clk);
    chk("R9 shutdown pwm next clk", int'(pwmOut), 0);
    chk("R9 shutdown dir next clk", int'(dirOut), 0);
    measure(1024, hi, dh);
    chk("R9 shutdown pwm window", hi + dh, 0);
    shdnN = 1'b1;
    runDuty("R9 shutdown restore", -200, 624, 1, 1024);
    @(negedge clk);
    faultOff = 1'b1;
    @(negedge clk);
    chk("R9 fault dir next clk", int'(dirOut), 0);
    measure(1024, hi, dh);
    chk("R9 fault window", hi + dh, 0);
    faultOff = 1'b0;
    runDuty("R9 fault restore", -200, 624, 1, 1024);
  endtask

  initial begin
    tReset();
    tCoolHeat();
    tUpdate();
    tRate();
    tExt();
    tOff();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule